// File: doc/BRIEF.md
# Serial flash write-protection controller

This block sits behind the command decoder of a 16 Mbit serial flash and rules on every command that could change stored state. It receives one decoded strobe per command: set write enable, clear write enable, load status, page program, sector erase and bulk erase. Program and erase strobes come with a 21-bit byte address. One clock later it answers with either an accept pulse or a reject pulse. On that same edge it updates the write-enable latch, the status lock bit and the three block-protect bits, which it also exposes on its outputs.

Locking of the status bits depends on two things: the stored lock bit and the live level of the active-low write-protect pin. When both are asserted, the device is in hardware-protected mode. This mode is reached whichever of the two conditions comes first. Releasing the pin high is the only way out. The block-protect bits mark the top part of the 32 sectors (64 KB each) as read-only. The rule is:

| Code | Sectors protected |
|------|-------------------|
| 0 | none |
| 1 to 5 | the top 1, 2, 4, 8 or 16 |
| 6 and 7 | all |

Top module: `flash_wp_ctrl`

## Requirements
- R1: After reset, the lock bit, the block-protect bits and the write-enable latch are all 0, and neither the accept pulse nor the reject pulse is asserted.
- R2: A strobe in one cycle gives exactly one of the accept or reject pulses in the next cycle. A cycle with no strobe gives neither pulse in the next cycle.
- R3: The set-write-enable strobe is always accepted and sets the latch. The clear-write-enable strobe is always accepted and clears the latch.
- R4: A status load, page program, sector erase or bulk erase issued while the latch is 0 is rejected, and the latch and status bits do not change.
- R5: While the lock bit is 0 and the latch is set, a status load is accepted at either pin level. It copies `new_lock` into the lock bit and `new_bp` into the block-protect bits.
- R6: While the lock bit is 1 and the pin is high, a status load with the latch set is accepted and loads the new values.
- R7: While the lock bit is 1 and the pin is low, every status load is rejected, even with the latch set. The lock bit, the block-protect bits and the latch keep their values.
- R8: `hw_locked` is high exactly when the lock bit is 1 and the pin is low. It can be entered by loading the lock bit with the pin already low, or by pulling the pin low with the lock bit already 1. Raising the pin leaves it.
- R9: Address bits 20:16 give the sector index. Page program or sector erase to a sector inside the region selected by the block-protect code is rejected, following the decode in the table above.
- R10: Page program or sector erase to a sector outside the protected region is accepted when the latch is set.
- R11: Bulk erase is accepted only when the block-protect code is 0 and the latch is set. With any nonzero code it is rejected.
- R12: An accepted status load, program or erase clears the latch. A rejected command leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_n | input | 1 | Write-protect pin, active low, already synchronous to clk |
| cmd_wren | input | 1 | Set-write-enable strobe |
| cmd_wrdi | input | 1 | Clear-write-enable strobe |
| cmd_wrsr | input | 1 | Status load strobe |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Bulk erase strobe |
| cmd_addr | input | 21 | Byte address for program and erase |
| new_lock | input | 1 | Lock bit value carried by a status load |
| new_bp | input | 3 | Block-protect code carried by a status load |
| cmd_ok | output | 1 | Accept pulse, one cycle after the strobe |
| cmd_rej | output | 1 | Reject pulse, one cycle after the strobe |
| wel | output | 1 | Write-enable latch |
| lock_bit | output | 1 | Stored status lock bit |
| bp | output | 3 | Stored block-protect code |
| hw_locked | output | 1 | Hardware-protected mode active |

## Verification
The assertions assume that the upstream decoder raises at most one command strobe per cycle. The assertions also assume that `wp_n` has already been brought into the clock domain, so its level in the strobe cycle is the level that counts. The bench drives each strobe for exactly one cycle and leaves at least one strobe-free cycle between commands. It changes the pin only between commands, so every response can be traced to a single command.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int ADDR_W    = 21,
  parameter int SECTOR_AW = 16,
  parameter int BP_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              new_lock,
  input  logic [BP_W-1:0]   new_bp,
  output logic              cmd_ok,
  output logic              cmd_rej,
  output logic              wel,
  output logic              lock_bit,
  output logic [BP_W-1:0]   bp,
  output logic              hw_locked
);

  localparam int SECT_W = ADDR_W - SECTOR_AW;
  localparam int NSECT  = 1 << SECT_W;

  logic [SECT_W-1:0] sector;
  logic [SECT_W:0]   prot_cnt;
  logic              addr_prot;
  logic              any_cmd, go_wrsr, go_prog, go_bulk, accept;

  assign sector    = cmd_addr[ADDR_W-1:SECTOR_AW];
  assign hw_locked = lock_bit & ~wp_n;

  always_comb begin
    prot_cnt = '0;
    for (int k = 1; k <= SECT_W; k++)
      if (int'(bp) == k) prot_cnt = (SECT_W+1)'(1) << (k - 1);
    if (int'(bp) > SECT_W) prot_cnt = (SECT_W+1)'(NSECT);
  end

  assign addr_prot = (prot_cnt != '0) &&
                     ({1'b0, sector} >= ((SECT_W+1)'(NSECT) - prot_cnt));

  assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be;
  assign go_wrsr = cmd_wrsr & wel & ~hw_locked;
  assign go_prog = (cmd_pp | cmd_se) & wel & ~addr_prot;
  assign go_bulk = cmd_be & wel & (bp == '0);
  assign accept  = cmd_wren | cmd_wrdi | go_wrsr | go_prog | go_bulk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ok   <= 1'b0;
      cmd_rej  <= 1'b0;
      wel      <= 1'b0;
      lock_bit <= 1'b0;
      bp       <= '0;
    end else begin
      cmd_ok  <= any_cmd & accept;
      cmd_rej <= any_cmd & ~accept;
      if (cmd_wren)                          wel <= 1'b1;
      else if (cmd_wrdi)                     wel <= 1'b0;
      else if (go_wrsr | go_prog | go_bulk)  wel <= 1'b0;
      if (go_wrsr) begin
        lock_bit <= new_lock;
        bp       <= new_bp;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be})); // R2
  AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> (cmd_ok != cmd_rej)); // R2
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> (!cmd_ok && !cmd_rej)); // R2
  AST_WREN_SETS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wren |=> (wel && cmd_ok)); // R3
  AST_LATCH_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_wrsr | cmd_pp | cmd_se | cmd_be) && !wel) |=> (cmd_rej && !wel)); // R4
  AST_HW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && lock_bit && !wp_n) |=> (cmd_rej && $stable(bp) && $stable(lock_bit))); // R7
  AST_BULK_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_be && bp != '0) |=> cmd_rej); // R11
  AST_REJECT_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_wrsr | cmd_pp | cmd_se | cmd_be) && wel) |=> (cmd_rej ? wel : !wel)); // R12

endmodule

// File: tb/test_flash_wp_ctrl.sv
module test_flash_wp_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0;
  logic [20:0] cmd_addr = '0;
  logic new_lock = 0;
  logic [2:0] new_bp = '0;
  logic cmd_ok, cmd_rej, wel, lock_bit, hw_locked;
  logic [2:0] bp;
  int checks = 0, errors = 0;

  localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PP = 3, C_SE = 4, C_BE = 5;

  always #4 clk = ~clk;

  flash_wp_ctrl i_flash_wp_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
    .cmd_addr(cmd_addr), .new_lock(new_lock), .new_bp(new_bp),
    .cmd_ok(cmd_ok), .cmd_rej(cmd_rej), .wel(wel), .lock_bit(lock_bit),
    .bp(bp), .hw_locked(hw_locked));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input int c, input logic [20:0] a, input logic lk, input logic [2:0] b);
    @(negedge clk);
    cmd_wren = (c == C_WREN); cmd_wrdi = (c == C_WRDI); cmd_wrsr = (c == C_WRSR);
    cmd_pp = (c == C_PP); cmd_se = (c == C_SE); cmd_be = (c == C_BE);
    cmd_addr = a; new_lock = lk; new_bp = b;
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be} = '0;
  endtask

  task automatic resp(input string tag, input logic ok);
    chk({tag, " ok"}, cmd_ok, ok);
    chk({tag, " rej"}, cmd_rej, !ok);
  endtask

  task automatic set_status(input logic lk, input logic [2:0] b);
    send(C_WREN, '0, 0, 0);
    send(C_WRSR, '0, lk, b);
  endtask

  task automatic t_reset;
    chk("R1 lock", lock_bit, 0); chk("R1 bp", bp, 0); chk("R1 wel", wel, 0);
    chk("R1 ok", cmd_ok, 0); chk("R1 rej", cmd_rej, 0);
  endtask

  task automatic t_latch;
    send(C_PP, 21'h000100, 0, 0); resp("R4 pp no latch", 0); chk("R4 wel", wel, 0);
    send(C_WRSR, '0, 1, 3'd5); resp("R4 wrsr no latch", 0);
    chk("R4 bp", bp, 0); chk("R4 lock", lock_bit, 0);
    send(C_BE, '0, 0, 0); resp("R4 be no latch", 0);
    send(C_WREN, '0, 0, 0); resp("R3 wren", 1); chk("R3 wel set", wel, 1);
    @(negedge clk); chk("R2 idle ok", cmd_ok, 0); chk("R2 idle rej", cmd_rej, 0);
    send(C_WRDI, '0, 0, 0); resp("R3 wrdi", 1); chk("R3 wel clr", wel, 0);
  endtask

  task automatic t_unlocked_pin_low;
    wp_n = 0;
    set_status(0, 3'd3); resp("R5 wrsr pin low", 1);
    chk("R5 bp", bp, 3); chk("R12 wel after wrsr", wel, 0); chk("R8 no lock", hw_locked, 0);
    wp_n = 1;
  endtask

  function automatic bit exp_prot(input int code, input int sec);
    if (code == 0) return 0;
    if (code >= 6) return 1;
    return sec >= 32 - (1 << (code - 1));
  endfunction

  task automatic t_regions;
    for (int code = 0; code < 8; code++) begin
      set_status(0, 3'(code)); chk("R9 bp load", bp, code);
      for (int j = 0; j < 4; j++) begin
        int n, sec;
        bit p;
        n = (code == 0) ? 0 : (code >= 6) ? 32 : (1 << (code - 1));
        sec = (j == 0) ? 0 : (j == 1) ? 31 : (j == 2) ? 32 - n : 31 - n;
        if (sec > 31) sec = 31;
        if (sec < 0) sec = 0;
        p = exp_prot(code, sec);
        send(C_WREN, '0, 0, 0);
        send((j % 2) ? C_SE : C_PP, {5'(sec), 16'h1234}, 0, 0);
        resp(p ? "R9 protected" : "R10 open", !p);
        chk("R12 latch after", wel, p);
        if (p) send(C_WRDI, '0, 0, 0);
      end
    end
  endtask

  task automatic t_bulk;
    set_status(0, 3'd0);
    send(C_WREN, '0, 0, 0); send(C_BE, '0, 0, 0); resp("R11 be open", 1);
    chk("R12 wel after be", wel, 0);
    set_status(0, 3'd1);
    send(C_WREN, '0, 0, 0); send(C_BE, '0, 0, 0); resp("R11 be guarded", 0);
    chk("R12 wel kept", wel, 1);
    send(C_WRDI, '0, 0, 0);
  endtask

  task automatic t_lock_then_pin;
    wp_n = 1;
    set_status(1, 3'd2); resp("R6 wrsr lock pin high", 1);
    chk("R6 lock", lock_bit, 1); chk("R8 not locked pin high", hw_locked, 0);
    set_status(1, 3'd4); resp("R6 reload", 1); chk("R6 bp", bp, 4);
    @(negedge clk); wp_n = 0; #1; chk("R8 pin low enters", hw_locked, 1);
    set_status(0, 3'd0); resp("R7 wrsr locked", 0);
    chk("R7 bp kept", bp, 4); chk("R7 lock kept", lock_bit, 1); chk("R7 wel kept", wel, 1);
    @(negedge clk); wp_n = 1; #1; chk("R8 pin high exits", hw_locked, 0);
    send(C_WRSR, '0, 0, 3'd0); resp("R6 after exit", 1); chk("R6 lock cleared", lock_bit, 0);
  endtask

  task automatic t_pin_then_lock;
    @(negedge clk); wp_n = 0;
    set_status(1, 3'd1); resp("R5 lock with pin low", 1);
    chk("R8 lock enters", hw_locked, 1);
    set_status(0, 3'd0); resp("R7 second wrsr", 0); chk("R7 bp", bp, 1);
    @(negedge clk); wp_n = 1; #1; chk("R8 exit", hw_locked, 0);
    send(C_WRSR, '0, 0, 3'd0); resp("R6 unlock", 1); chk("R6 bp zero", bp, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_unlocked_pin_low;
    t_regions;
    t_bulk;
    t_lock_then_pin;
    t_pin_then_lock;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule